// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block supervises a host processor and drives its active-low reset line. The host restarts the watchdog by pulling a shared select line from high to low. The same line also serves as the chip select of a serial memory bus, so normal bus traffic keeps the watchdog alive. If the watchdog is enabled and the line shows no falling edge for the selected timeout, the block pulls reset low. This happens whether the line has been idle high or stuck low.

A supply-fault input asserts reset as well. Reset is also asserted straight after power-on. In each case reset is released only after the supply has been good for a fixed hold period, counted in cycles of the block clock. A small control register holds three settings: the timeout choice, a watchdog-off bit and a protect-enable bit. While the write-protect pin is asserted and protect-enable is set, writes to the register are refused and flagged.

Top module: `wdt_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_out_n` is low and `cfg_q` holds its initial value (default 4'b0000). After `por_n` rises with the supply good, `rst_out_n` rises after exactly HOLD_CYCLES clock edges.
- R2: A high `supply_low` sampled at a clock edge drives `rst_out_n` low at that edge. `rst_out_n` returns high only after HOLD_CYCLES consecutive edges with `supply_low` low.
- R3: A high-to-low transition on `sel_n` restarts the watchdog count. Transitions spaced closer than the timeout keep `rst_out_n` high.
- R4: With the watchdog enabled and `rst_out_n` high, `rst_out_n` falls after exactly the selected timeout in cycles if `sel_n` has no falling edge. This holds with `sel_n` held high and with `sel_n` held low.
- R5: A watchdog reset keeps `rst_out_n` low for HOLD_CYCLES cycles. After release, a complete new timeout must pass before the next watchdog reset.
- R6: `cfg_q[1:0]` selects the timeout: 0 gives TMO0, 1 gives TMO1, 2 gives TMO2 and 3 gives TMO3 cycles.
- R7: `cfg_q[2]` = 1 disables the watchdog. With the supply good, `rst_out_n` then stays high however long `sel_n` stays idle.
- R8: A `cfg_valid` write that is not locked loads `cfg_data` into `cfg_q` at the next edge, and `wr_err` stays low.
- R9: The register is locked when `wp_n` is low and `cfg_q[3]` is 1. A locked write leaves `cfg_q` unchanged, including bit 3, and pulses `wr_err` high for the one cycle after that write.
- R10: With `wp_n` high, writes are accepted even when `cfg_q[3]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low | input | 1 | Supply-fault indication, high while the supply is below threshold |
| sel_n | input | 1 | Shared select / watchdog kick line; its falling edges restart the watchdog |
| wp_n | input | 1 | Write-protect pin, active low |
| cfg_valid | input | 1 | Control-register write strobe |
| cfg_data | input | 4 | Write data: [1:0] timeout select, [2] watchdog off, [3] protect enable |
| cfg_q | output | 4 | Current control-register value |
| wr_err | output | 1 | One-cycle pulse when a write was refused by the lock |
| rst_out_n | output | 1 | Reset to the host, active low |

## Verification
The bench builds the block with a hold period of 20 cycles and timeouts of 40, 80, 160 and 320 cycles. With these values every full-length timeout, every hold period and every choice of timeout select can be measured to the exact cycle in a short run. They also allow the disabled watchdog to be observed across a window longer than the largest timeout. The lock rules are walked as a sequence of register writes in which each step depends on the value the previous step left behind.

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int unsigned HOLD_CYCLES = 800_000,
  parameter int unsigned TMO0 = 150_000,
  parameter int unsigned TMO1 = 600_000,
  parameter int unsigned TMO2 = 1_400_000,
  parameter int unsigned TMO3 = 3_000_000,
  parameter logic [3:0]  CFG_INIT = 4'b0000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supply_low,
  input  logic       sel_n,
  input  logic       wp_n,
  input  logic       cfg_valid,
  input  logic [3:0] cfg_data,
  output logic [3:0] cfg_q,
  output logic       wr_err,
  output logic       rst_out_n
);
  localparam int unsigned TMAX01 = (TMO0 > TMO1) ? TMO0 : TMO1;
  localparam int unsigned TMAX23 = (TMO2 > TMO3) ? TMO2 : TMO3;
  localparam int unsigned TMAX   = (TMAX01 > TMAX23) ? TMAX01 : TMAX23;
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int WW = $clog2(TMAX + 1);

  logic [2:0]    sel_sync;
  logic          kick;
  logic          locked;
  logic [WW-1:0] wd_cnt, period, per_last;
  logic          wd_active, wd_fire;
  logic [HW-1:0] hold_cnt, hold_nxt;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) sel_sync <= 3'b111;
    else        sel_sync <= {sel_sync[1:0], sel_n};

  assign kick = sel_sync[2] & ~sel_sync[1];

  assign locked = ~wp_n & cfg_q[3];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      cfg_q  <= CFG_INIT;
      wr_err <= 1'b0;
    end else begin
      wr_err <= cfg_valid & locked;
      if (cfg_valid && !locked) cfg_q <= cfg_data;
    end

  always_comb
    case (cfg_q[1:0])
      2'd0:    period = WW'(TMO0);
      2'd1:    period = WW'(TMO1);
      2'd2:    period = WW'(TMO2);
      default: period = WW'(TMO3);
    endcase

  assign per_last  = period - WW'(1);
  assign wd_active = rst_out_n & ~cfg_q[2];
  assign wd_fire   = wd_active & ~kick & (wd_cnt == per_last);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                  wd_cnt <= '0;
    else if (!wd_active || kick) wd_cnt <= '0;
    else                         wd_cnt <= wd_cnt + WW'(1);

  always_comb
    if (supply_low || wd_fire)          hold_nxt = '0;
    else if (hold_cnt != HW'(HOLD_CYCLES)) hold_nxt = hold_cnt + HW'(1);
    else                                hold_nxt = hold_cnt;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      hold_cnt  <= '0;
      rst_out_n <= 1'b0;
    end else begin
      hold_cnt  <= hold_nxt;
      rst_out_n <= (hold_nxt == HW'(HOLD_CYCLES));
    end
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk (
  input logic       clk,
  input logic       por_n,
  input logic       supply_low,
  input logic       wp_n,
  input logic       cfg_valid,
  input logic [3:0] cfg_data,
  input logic [3:0] cfg_q,
  input logic       wr_err,
  input logic       rst_out_n
);
  p_supply_low_r2: assert property (@(posedge clk) disable iff (!por_n)
    supply_low |=> !rst_out_n);

  p_release_good_r2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> !$past(supply_low));

  p_wd_off_r7: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_q[2] && !supply_low && rst_out_n) |=> rst_out_n);

  p_accept_r8: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_valid && !(!wp_n && cfg_q[3])) |=> (cfg_q == $past(cfg_data)) && !wr_err);

  p_locked_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (cfg_valid && !wp_n && cfg_q[3]) |=> $stable(cfg_q) && wr_err);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!por_n)
    wr_err |-> $past(cfg_valid));
endmodule

bind wdt_supervisor wdt_supervisor_chk chk_i (.*);

// File: tb/wdt_supervisor_tb_top.sv
module wdt_supervisor_tb_top;
  localparam int HOLD = 20;
  localparam int T0 = 40, T1 = 80, T2 = 160, T3 = 320;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       supply_low = 1'b0;
  logic       sel_n = 1'b1;
  logic       wp_n = 1'b1;
  logic       cfg_valid = 1'b0;
  logic [3:0] cfg_data = 4'd0;
  logic [3:0] cfg_q;
  logic       wr_err;
  logic       rst_out_n;

  always #5 clk = ~clk;

  wdt_supervisor #(
    .HOLD_CYCLES(HOLD), .TMO0(T0), .TMO1(T1), .TMO2(T2), .TMO3(T3), .CFG_INIT(4'b0000)
  ) dut_i (
    .clk(clk), .por_n(por_n), .supply_low(supply_low), .sel_n(sel_n), .wp_n(wp_n),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_q(cfg_q), .wr_err(wr_err),
    .rst_out_n(rst_out_n)
  );

  // {wp_n, write data, expected cfg_q, expected wr_err}, applied in order
  localparam logic [9:0] VEC [8] = '{
    10'b1_0101_0101_0,
    10'b0_0011_0011_0,
    10'b0_1100_1100_0,
    10'b0_0000_1100_1,
    10'b0_1001_1100_1,
    10'b1_0110_0110_0,
    10'b0_0000_0000_0,
    10'b1_0100_0100_0
  };

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_por(input logic sel_lvl);
    por_n = 1'b0; sel_n = sel_lvl; supply_low = 1'b0; cfg_valid = 1'b0; wp_n = 1'b1;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
  endtask

  task automatic wait_level(input logic lvl, output int n);
    n = 0;
    while (rst_out_n != lvl && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic write_cfg(input logic wp, input logic [3:0] d);
    wp_n = wp; cfg_data = d; cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual run still busy expected finished");
    finish_run();
  end

  initial begin
    int n;
    // R1: reset state and power-on hold
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rst_out_n in por", rst_out_n, 0);
    check("R1 cfg_q in por", cfg_q, 0);
    check("R1 wr_err in por", wr_err, 0);
    por_n = 1'b1;
    wait_level(1'b1, n);
    check("R1 power-on hold cycles", n, HOLD);

    // R8 R9 R10: table of control writes
    for (int i = 0; i < 8; i++) begin
      write_cfg(VEC[i][9], VEC[i][8:5]);
      if (VEC[i][0])  begin check("R9 locked cfg_q", cfg_q, VEC[i][4:1]); check("R9 wr_err", wr_err, 1); end
      else if (i == 5) begin check("R10 wp high cfg_q", cfg_q, VEC[i][4:1]); check("R10 wr_err", wr_err, 0); end
      else            begin check("R8 cfg_q", cfg_q, VEC[i][4:1]); check("R8 wr_err", wr_err, 0); end
    end
    @(negedge clk);
    check("R9 wr_err one cycle", wr_err, 0);

    // R4 R5: idle high, timeout, hold, full new timeout
    do_por(1'b1);
    wait_level(1'b1, n);
    wait_level(1'b0, n);
    check("R4 timeout idle high", n, T0);
    wait_level(1'b1, n);
    check("R5 watchdog reset length", n, HOLD);
    wait_level(1'b0, n);
    check("R5 new full timeout", n, T0);

    // R4: idle low
    do_por(1'b0);
    wait_level(1'b1, n);
    wait_level(1'b0, n);
    check("R4 timeout idle low", n, T0);

    // R3: regular kicks keep reset high
    do_por(1'b1);
    wait_level(1'b1, n);
    n = 0;
    for (int k = 0; k < 12; k++) begin
      sel_n = 1'b0;
      repeat (2) @(negedge clk);
      if (!rst_out_n) n++;
      sel_n = 1'b1;
      for (int j = 0; j < 28; j++) begin
        @(negedge clk);
        if (!rst_out_n) n++;
      end
    end
    check("R3 low cycles under kicks", n, 0);

    // R6: each timeout select
    for (int s = 1; s < 4; s++) begin
      do_por(1'b1);
      write_cfg(1'b1, 4'(s));
      wait_level(1'b1, n);
      wait_level(1'b0, n);
      check("R6 timeout for select", n, (s == 1) ? T1 : (s == 2) ? T2 : T3);
    end

    // R7: disabled watchdog never fires
    do_por(1'b1);
    write_cfg(1'b1, 4'b0100);
    wait_level(1'b1, n);
    n = 0;
    repeat (500) begin
      @(negedge clk);
      if (!rst_out_n) n++;
    end
    check("R7 low cycles with watchdog off", n, 0);

    // R2: supply fault, short and long
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
    check("R2 reset on supply fault", rst_out_n, 0);
    wait_level(1'b1, n);
    check("R2 hold after short fault", n, HOLD);
    supply_low = 1'b1;
    n = 0;
    repeat (50) begin
      @(negedge clk);
      if (rst_out_n) n++;
    end
    check("R2 high cycles during fault", n, 0);
    supply_low = 1'b0;
    wait_level(1'b1, n);
    check("R2 hold after long fault", n, HOLD);

    finish_run();
  end
endmodule